// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block connects a simple synchronous processor memory bus to an asynchronous DRAM whose row and column addresses share a single set of pins. The processor presents a byte address, optional write data, a read or a write strobe and a size flag. It holds all of them until the controller returns a one-cycle ready pulse. The controller splits the word address into a row half and a column half. It drives the row half on the shared pins and lowers the row strobe. It then drives the column half and lowers the column strobe. During a read it also lowers the output enable, and during a write it lowers the write enable and the byte-lane write masks.

After an access the row stays open. A later request to the same row goes straight to a column pulse, which gives page-mode runs. A request to another row first closes the open row and waits out the precharge time. A free-running timer schedules refreshes. A pending refresh takes priority over the next processor request: the controller closes any open row and then runs a column-before-row refresh cycle. The row-to-column delay, column pulse width, read latency, precharge time and refresh interval are all parameters.

Top module: `dram_mux_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are high, and `cpu_ready` and `cpu_rdata` are zero.
- R2: The word address is `cpu_addr[16:1]`. Its upper 8 bits appear on `dram_addr` when `dram_ras_n` falls, and its lower 8 bits appear on `dram_addr` when `dram_cas_n` falls.
- R3: `dram_cas_n` falls no sooner than T_RCD cycles after `dram_ras_n` falls, and `dram_ras_n` stays high for at least T_RP cycles before it falls again. On a closed row, ready rises T_RCD+CAS_LEN edges after the first edge that sees the request, where CAS_LEN = max(T_CAS, T_LAT).
- R4: `dram_oe_n` is low only while both strobes are low, and `dram_we_n` and `dram_oe_n` are never low together.
- R5: A read samples `dram_din` after the column strobe has been low for CAS_LEN cycles. The word written last to that address is returned on `cpu_rdata`.
- R6: `cpu_ready` is high for exactly one cycle per transaction. `cpu_rdata` changes only with that pulse and stays stable until the next transaction completes.
- R7: A request to the open row causes no new row activation, and ready rises CAS_LEN edges after the first edge that sees it.
- R8: A request to a different row releases the row strobe and waits out the precharge time before activating the new row. Ready rises T_RP+1+T_RCD+CAS_LEN edges after the first edge that sees the request.
- R9: When `cpu_word` is 0 the access is a byte access and `cpu_addr[0]` selects the lane: 0 is bits 7:0 and 1 is bits 15:8. A byte write drives `cpu_wdata[7:0]` on both lanes and lowers only the selected active-low mask bit (`dram_lane_n[1]` for the upper lane, `dram_lane_n[0]` for the lower lane), so the other lane keeps its old value. A byte read returns the selected byte in bits 7:0 with bits 15:8 zero.
- R10: A refresh is a column-strobe fall while the row strobe is high, followed by a row-strobe fall on the next cycle. Refreshes recur every REFRESH_INTERVAL cycles to within a few access lengths, even during an unbroken run of same-row requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | ROW_W+COL_W+1 | Byte address; bit 0 selects the lane |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rd | input | 1 | Read strobe, held until ready |
| cpu_wr | input | 1 | Write strobe, held until ready |
| cpu_word | input | 1 | 1 for a word access, 0 for a byte access |
| cpu_rdata | output | DATA_W | Read data, held after ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| dram_addr | output | PIN_W | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_lane_n | output | 2 | Byte-lane write masks, active low |
| dram_dout | output | DATA_W | Data to the DRAM |
| dram_din | input | DATA_W | Data from the DRAM |

## Verification
Word writes and reads with all-zero, all-one and alternating data patterns at several rows and columns show whether row and column halves are swapped or mis-sliced. Reading them back in reverse order forces row misses between them. A short sequence of hit, miss and hit requests separates the three latencies and counts row activations, which shows whether the open page is reused or reopened. Byte writes to each lane followed by word and byte reads show whether the masks protect the neighbouring lane. A long unbroken run of same-row reads shows whether refresh still preempts the processor when no row miss ever closes the page.

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  parameter int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  parameter int DATA_W = 16,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_LAT = 3,
  parameter int T_RP = 2,
  parameter int REFRESH_INTERVAL = 780
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ROW_W+COL_W:0]   cpu_addr,
  input  logic [DATA_W-1:0]      cpu_wdata,
  input  logic                   cpu_rd,
  input  logic                   cpu_wr,
  input  logic                   cpu_word,
  output logic [DATA_W-1:0]      cpu_rdata,
  output logic                   cpu_ready,
  output logic [PIN_W-1:0]       dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [1:0]             dram_lane_n,
  output logic [DATA_W-1:0]      dram_dout,
  input  logic [DATA_W-1:0]      dram_din
);

  localparam int LANE_W   = DATA_W / 2;
  localparam int CAS_LEN  = (T_CAS > T_LAT) ? T_CAS : T_LAT;
  localparam int WAIT_A   = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int WAIT_MAX = (WAIT_A > CAS_LEN) ? WAIT_A : CAS_LEN;
  localparam int CNT_W    = $clog2(WAIT_MAX + 1);
  localparam int REF_W    = $clog2(REFRESH_INTERVAL + 1);

  typedef enum logic [2:0] {S_IDLE, S_RCD, S_CAS, S_PRE, S_REFC, S_REFR} state_t;

  state_t             st;
  logic [CNT_W-1:0]   cnt;
  logic [REF_W-1:0]   ref_cnt;
  logic               ref_pend;
  logic               row_open;
  logic [ROW_W-1:0]   open_row;

  logic [ROW_W-1:0]   req_row;
  logic [COL_W-1:0]   req_col;
  logic               req, is_write, row_hit, launch, start_ref, ref_tick;
  logic [1:0]         lane_sel_n;
  logic [DATA_W-1:0]  wr_data, rd_data;

  assign req_row    = cpu_addr[ROW_W+COL_W -: ROW_W];
  assign req_col    = cpu_addr[COL_W:1];
  assign req        = cpu_rd | cpu_wr;
  assign is_write   = cpu_wr & ~cpu_rd;
  assign row_hit    = row_open && (open_row == req_row);
  assign launch     = (st == S_IDLE && !ref_pend && req && row_hit) ||
                      (st == S_RCD && cnt == '0);
  assign start_ref  = (st == S_IDLE) && ref_pend && !row_open;
  assign ref_tick   = (ref_cnt == REF_W'(REFRESH_INTERVAL - 1));
  assign lane_sel_n = cpu_word ? 2'b00 : (cpu_addr[0] ? 2'b01 : 2'b10);
  assign wr_data    = cpu_word ? cpu_wdata : {2{cpu_wdata[LANE_W-1:0]}};
  assign rd_data    = cpu_word ? dram_din :
                      {{LANE_W{1'b0}}, cpu_addr[0] ? dram_din[DATA_W-1:LANE_W] : dram_din[LANE_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt  <= '0;
      ref_pend <= 1'b0;
    end else begin
      ref_cnt <= ref_tick ? '0 : ref_cnt + 1'b1;
      if (ref_tick)       ref_pend <= 1'b1;
      else if (start_ref) ref_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_lane_n <= 2'b11;
      dram_addr   <= '0;
      dram_dout   <= '0;
      cpu_rdata   <= '0;
      cpu_ready   <= 1'b0;
      row_open    <= 1'b0;
      open_row    <= '0;
    end else begin
      cpu_ready <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (ref_pend) begin
            if (row_open) begin
              dram_ras_n <= 1'b1;
              row_open   <= 1'b0;
              st         <= S_PRE;
              cnt        <= CNT_W'(T_RP - 1);
            end else begin
              dram_cas_n <= 1'b0;
              st         <= S_REFC;
            end
          end else if (req && !row_hit) begin
            if (row_open) begin
              dram_ras_n <= 1'b1;
              row_open   <= 1'b0;
              st         <= S_PRE;
              cnt        <= CNT_W'(T_RP - 1);
            end else begin
              dram_addr  <= PIN_W'(req_row);
              dram_ras_n <= 1'b0;
              row_open   <= 1'b1;
              open_row   <= req_row;
              st         <= S_RCD;
              cnt        <= CNT_W'(T_RCD - 1);
            end
          end
        end
        S_RCD: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
        end
        S_CAS: begin
          if (cnt == '0) begin
            if (!dram_oe_n) cpu_rdata <= rd_data;
            dram_cas_n  <= 1'b1;
            dram_oe_n   <= 1'b1;
            dram_we_n   <= 1'b1;
            dram_lane_n <= 2'b11;
            cpu_ready   <= 1'b1;
            st          <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_PRE: begin
          if (cnt == '0) st <= S_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        S_REFC: begin
          dram_ras_n <= 1'b0;
          st         <= S_REFR;
          cnt        <= CNT_W'(CAS_LEN - 1);
        end
        S_REFR: begin
          if (cnt == '0) begin
            dram_ras_n <= 1'b1;
            dram_cas_n <= 1'b1;
            st         <= S_PRE;
            cnt        <= CNT_W'(T_RP - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (launch) begin
        dram_addr   <= PIN_W'(req_col);
        dram_cas_n  <= 1'b0;
        dram_oe_n   <= ~cpu_rd;
        dram_we_n   <= ~is_write;
        dram_lane_n <= is_write ? lane_sel_n : 2'b11;
        dram_dout   <= wr_data;
        st          <= S_CAS;
        cnt         <= CNT_W'(CAS_LEN - 1);
      end
    end
  end

endmodule

// File: rtl/dram_mux_ctrl_chk.sv
module dram_mux_ctrl_chk #(
  parameter int T_RCD = 2,
  parameter int T_RP = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic cpu_ready
);

  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      lo_cnt <= ras_n ? '0 : ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt <= !ras_n ? '0 : ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1);
    end
  end

  // R4
  oe_needs_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ras_n && !cas_n));

  // R4
  we_oe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));

  // R6
  ready_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  // R3
  row_to_col_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n) |-> (lo_cnt >= 16'(T_RCD)));

  // R3
  precharge_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= 16'(T_RP)));

  // R10
  refresh_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && ras_n) |=> !ras_n);

endmodule

bind dram_mux_ctrl dram_mux_ctrl_chk #(.T_RCD(T_RCD), .T_RP(T_RP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .oe_n(dram_oe_n), .cpu_ready(cpu_ready)
);

// File: tb/dram_mux_ctrl_test.sv
module dram_mux_ctrl_test;
  localparam int CLK_NS  = 10;
  localparam int T_RCD   = 2;
  localparam int T_CAS   = 2;
  localparam int T_LAT   = 3;
  localparam int T_RP    = 2;
  localparam int REF_INT = 60;
  localparam int CAS_LEN = (T_CAS > T_LAT) ? T_CAS : T_LAT;
  localparam int SLACK   = 16;

  logic clk, rst_n;
  logic [16:0] cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata, dram_dout, dram_din;
  logic cpu_rd, cpu_wr, cpu_word, cpu_ready;
  logic [7:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
  logic [1:0] dram_lane_n;

  dram_mux_ctrl #(.ROW_W(8), .COL_W(8), .DATA_W(16), .T_RCD(T_RCD), .T_CAS(T_CAS),
                  .T_LAT(T_LAT), .T_RP(T_RP), .REFRESH_INTERVAL(REF_INT)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_word(cpu_word), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_lane_n(dram_lane_n), .dram_dout(dram_dout), .dram_din(dram_din));

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  // behavioural DRAM model
  logic [15:0] mem [int];
  logic ras_q, cas_q;
  logic [7:0] m_row, m_col;
  logic [15:0] m_rdata;
  int cas_lo, acts, refs, gap, max_gap, min_gap;
  bit seen_ref;
  int key;
  logic [15:0] old_w, new_w;

  assign dram_din = (!dram_oe_n && cas_lo >= T_LAT - 1) ? m_rdata : 16'hBAD0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ras_q <= 1'b1; cas_q <= 1'b1; cas_lo <= 0; acts <= 0; refs <= 0;
      gap <= 0; max_gap <= 0; min_gap <= 1000000; seen_ref <= 1'b0;
      m_row <= '0; m_col <= '0; m_rdata <= '0;
    end else begin
      ras_q  <= dram_ras_n;
      cas_q  <= dram_cas_n;
      cas_lo <= dram_cas_n ? 0 : cas_lo + 1;
      if (!dram_ras_n && ras_q) begin
        if (!dram_cas_n) begin
          refs <= refs + 1;
          if (seen_ref && gap < min_gap) min_gap <= gap;
          if (gap > max_gap) max_gap <= gap;
          gap <= 0;
          seen_ref <= 1'b1;
        end else begin
          acts  <= acts + 1;
          m_row <= dram_addr;
          gap   <= gap + 1;
        end
      end else begin
        gap <= gap + 1;
      end
      if (!dram_cas_n && cas_q && !dram_ras_n) begin
        key   = {m_row, dram_addr};
        old_w = mem.exists(key) ? mem[key] : 16'h0000;
        m_col <= dram_addr;
        m_rdata <= old_w;
        if (!dram_we_n) begin
          new_w = old_w;
          if (!dram_lane_n[0]) new_w[7:0]  = dram_dout[7:0];
          if (!dram_lane_n[1]) new_w[15:8] = dram_dout[15:8];
          mem[key] = new_w;
        end
      end
      if (!dram_oe_n)
        chk(!dram_ras_n && !dram_cas_n, "R4 output enable without both strobes",
            {dram_ras_n, dram_cas_n}, 0);
    end
  end

  // ready pulse monitor (R6)
  logic rdy_q;
  always @(negedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else begin
      if (cpu_ready) chk(!rdy_q, "R6 ready longer than one cycle", 2, 1);
      rdy_q <= cpu_ready;
    end
  end

  // bench shadow memory and CPU side
  logic [15:0] shadow [int];
  logic [15:0] held;
  bit have_held = 1'b0;

  function automatic logic [15:0] expect_rd(input logic [16:0] a, input logic word);
    logic [15:0] w;
    w = shadow.exists(int'(a[16:1])) ? shadow[int'(a[16:1])] : 16'h0000;
    if (word) return w;
    return {8'h00, a[0] ? w[15:8] : w[7:0]};
  endfunction

  task automatic access(input logic wr, input logic word, input logic [16:0] a,
                        input logic [15:0] wd, output logic [15:0] rd, output int cyc);
    logic [15:0] w;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = wd; cpu_word = word; cpu_rd = !wr; cpu_wr = wr;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (!cpu_ready && have_held)
        chk(cpu_rdata == held, "R6 read data moved before ready", cpu_rdata, held);
    end while (!cpu_ready && cyc < 200);
    chk(cpu_ready, "R6 ready never rose", 0, 1);
    rd = cpu_rdata;
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    if (wr) begin
      w = shadow.exists(int'(a[16:1])) ? shadow[int'(a[16:1])] : 16'h0000;
      if (word) w = wd;
      else if (a[0]) w[15:8] = wd[7:0];
      else w[7:0] = wd[7:0];
      shadow[int'(a[16:1])] = w;
    end else begin
      held = rd;
      have_held = 1'b1;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      if (have_held) chk(cpu_rdata == held, "R6 read data not held while idle", cpu_rdata, held);
    end
  endtask

  task automatic wait_refresh();
    int r0, t;
    r0 = refs; t = 0;
    while (refs == r0 && t < 400) begin @(negedge clk); t++; end
    chk(refs != r0, "R10 no refresh seen", refs, r0 + 1);
  endtask

  task automatic read_check(input logic word, input logic [16:0] a, input string tag);
    logic [15:0] rd, ex;
    int cyc;
    ex = expect_rd(a, word);
    access(1'b0, word, a, 16'h0, rd, cyc);
    chk(rd == ex, tag, rd, ex);
  endtask

  initial begin
    logic [15:0] rd;
    int cyc, a0, r0;
    logic [15:0] pats [4];
    logic [15:0] wads [4];
    pats = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h5A5A};
    wads = '{16'h2A00, 16'h2AFF, 16'hF000, 16'h00F0};
    rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_word = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF, "R1 strobes after reset",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
    chk(cpu_ready == 1'b0 && cpu_rdata == 16'h0, "R1 cpu outputs after reset", {cpu_ready, cpu_rdata}, 0);

    // R3 closed-row latency, R2 address halves
    access(1'b1, 1'b1, {16'h1203, 1'b0}, 16'h1234, rd, cyc);
    chk(cyc == T_RCD + CAS_LEN + 1, "R3 closed-row write latency", cyc, T_RCD + CAS_LEN + 1);
    chk(m_row == 8'h12, "R2 row half on pins at row strobe", m_row, 8'h12);
    chk(m_col == 8'h03, "R2 column half on pins at column strobe", m_col, 8'h03);
    read_check(1'b1, {16'h1203, 1'b0}, "R5 read back word");

    // R5 data patterns with row changes between them
    for (int i = 0; i < 4; i++) begin
      access(1'b1, 1'b1, {wads[i], 1'b0}, pats[i], rd, cyc);
      chk(m_row == wads[i][15:8] && m_col == wads[i][7:0], "R2 row/column split",
          {m_row, m_col}, wads[i]);
    end
    for (int i = 3; i >= 0; i--) read_check(1'b1, {wads[i], 1'b0}, "R5 pattern read back");

    // R7/R8 page hit versus row miss
    wait_refresh();
    a0 = acts;
    access(1'b1, 1'b1, {16'h4001, 1'b0}, 16'hC0DE, rd, cyc);
    access(1'b0, 1'b1, {16'h4001, 1'b0}, 16'h0, rd, cyc);
    chk(cyc == CAS_LEN + 1, "R7 same-row latency", cyc, CAS_LEN + 1);
    chk(rd == 16'hC0DE, "R7 same-row read data", rd, 16'hC0DE);
    access(1'b0, 1'b1, {16'h4177, 1'b0}, 16'h0, rd, cyc);
    chk(cyc == T_RP + T_RCD + CAS_LEN + 2, "R8 other-row latency", cyc, T_RP + T_RCD + CAS_LEN + 2);
    held = rd;
    access(1'b0, 1'b1, {16'h4178, 1'b0}, 16'h0, rd, cyc);
    chk(cyc == CAS_LEN + 1, "R7 hit after reopen latency", cyc, CAS_LEN + 1);
    chk(acts - a0 == 2, "R7 R8 row activations", acts - a0, 2);

    // R9 byte lanes
    access(1'b1, 1'b1, {16'h3344, 1'b0}, 16'h1234, rd, cyc);
    access(1'b1, 1'b0, {16'h3344, 1'b1}, 16'h55AB, rd, cyc);
    read_check(1'b1, {16'h3344, 1'b0}, "R9 upper byte write keeps lower lane");
    chk(shadow[16'h3344] == 16'hAB34, "R9 expected merged word", shadow[16'h3344], 16'hAB34);
    read_check(1'b0, {16'h3344, 1'b0}, "R9 byte read lower lane");
    read_check(1'b0, {16'h3344, 1'b1}, "R9 byte read upper lane");
    access(1'b1, 1'b0, {16'h3344, 1'b0}, 16'h77CD, rd, cyc);
    read_check(1'b1, {16'h3344, 1'b0}, "R9 lower byte write keeps upper lane");

    // R10 refresh preempts an unbroken same-row run
    wait_refresh();
    r0 = refs;
    access(1'b1, 1'b1, {16'h5501, 1'b0}, 16'h9E37, rd, cyc);
    for (int i = 0; i < 40; i++) read_check(1'b1, {16'h5501, 1'b0}, "R10 data across refreshes");
    chk(refs - r0 >= 2, "R10 refreshes during same-row run", refs - r0, 2);

    // R6 hold while idle, R10 spacing
    idle(150);
    chk(max_gap <= REF_INT + SLACK, "R10 longest refresh gap", max_gap, REF_INT + SLACK);
    chk(min_gap >= REF_INT - SLACK, "R10 shortest refresh gap", min_gap, REF_INT - SLACK);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog R1-all actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule